// File: doc/BRIEF.md
# Power-Management GPIO Register Bank

This block is the slave side of a power-management bus for four identical GPIO peripherals. Each request names a slave, a peripheral and a register offset. A request is either a single-byte write or a single-byte read. The block keeps a small register set for each peripheral. Each register applies its own write mask and its own read and write permissions.

Two registers have side effects. A write to the control register that selects output or bidirectional mode also copies its lowest data bit into bit 0 of the status register. The per-peripheral enable register gates every read of that peripheral to zero while it holds zero.

Requests outside the decoded address window are answered with an error. Every response comes back on the clock edge after the request. The pin drivers, interrupt logic and voltage selection are not part of this block.

Top module: `pmg_regfile`

## Requirements
- R1: A request is accepted only when the slave ID is 0, the peripheral ID lies in 0xC0..0xC3 and the offset is at most 0x46. Any other request raises `rsp_err` with `rsp_rdata` = 0 and changes no register.
- R2: Bits 1:0 of the peripheral ID pick one of four independent register sets. A write to one set leaves the other three unchanged.
- R3: After reset every set reads as follows: 0x04 = 0x10, 0x05 = 0x05, 0x42 = 0x04, 0x45 = 0x01, 0x46 = 0x80, and 0x08, 0x40 and 0x41 = 0x00.
- R4: Offsets 0x04 and 0x05 can be read but not written. Writes to them are ignored and raise no error.
- R5: A write to a writable register stores the data ANDed with that register's mask. The masks are 0x08: 0x81, 0x40: 0x7F, 0x41: 0x07, 0x42: 0x07, 0x45: 0x3F and 0x46: 0x80. The control register at 0x40 reads back its masked value.
- R6: Take the control data after the 0x7F mask. When its bits 5:4 are 01 or 10, the write also replaces status (0x08) bit 0 with data bit 0 and leaves the other status bits alone. When bits 5:4 are 00 or 11, the status register is left unchanged.
- R7: While the register at 0x46 of a set holds zero, every read of that set returns 0 without error. Writes still take effect, and the stored values show again once 0x46 is set nonzero.
- R8: Offsets inside the window that are not listed in R3 read 0, ignore writes and raise no error.
- R9: `rsp_rdata` and `rsp_err` are registered. They carry the response on the clock edge after the request and are 0 in any cycle that follows no request or follows a write without error.
- R10: While reset is asserted, both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_vld | input | 1 | A request is present this cycle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_sid | input | SID_W | Slave ID |
| req_pid | input | PID_W | Peripheral ID |
| req_off | input | 8 | Register offset |
| req_wdata | input | 8 | Write data |
| rsp_rdata | output | 8 | Read data, one cycle after the request |
| rsp_err | output | 1 | Address error, one cycle after the request |

## Verification
Each read result and each error flag appears exactly one clock edge after its request. A write is visible to the very next request. The bench therefore applies each request on a falling edge and samples the outputs on the next falling edge, after the single register stage has updated. It then moves straight on to the next request, so every write-then-read ordering is also exercised back to back. The idle cycle after a request is checked separately to confirm that both outputs fall back to zero.

// File: rtl/pmg_pkg.sv
package pmg_pkg;

  localparam int DW    = 8;
  localparam int OW    = 8;
  localparam int NSLOT = 6;

  localparam logic [OW-1:0] OFF_LAST   = 8'h46;
  localparam logic [OW-1:0] OFF_ID0    = 8'h04;
  localparam logic [OW-1:0] OFF_ID1    = 8'h05;
  localparam logic [OW-1:0] OFF_STATUS = 8'h08;
  localparam logic [OW-1:0] OFF_CTRL   = 8'h40;

  localparam logic [DW-1:0] ID0_VAL   = 8'h10;
  localparam logic [DW-1:0] ID1_VAL   = 8'h05;
  localparam logic [DW-1:0] CTRL_MASK = 8'h7F;

  localparam int SLOT_STATUS = 0;
  localparam int SLOT_CTRL   = 1;
  localparam int SLOT_ENABLE = 5;

  typedef struct packed {
    logic [OW-1:0] off;
    logic [DW-1:0] mask;
    logic [DW-1:0] rst;
  } slot_t;

  function automatic slot_t slot_info(input int idx);
    slot_t s;
    case (idx)
      0:       s = '{off: OFF_STATUS, mask: 8'h81,     rst: 8'h00};
      1:       s = '{off: OFF_CTRL,   mask: CTRL_MASK, rst: 8'h00};
      2:       s = '{off: 8'h41,      mask: 8'h07,     rst: 8'h00};
      3:       s = '{off: 8'h42,      mask: 8'h07,     rst: 8'h04};
      4:       s = '{off: 8'h45,      mask: 8'h3F,     rst: 8'h01};
      default: s = '{off: 8'h46,      mask: 8'h80,     rst: 8'h80};
    endcase
    return s;
  endfunction

  function automatic logic ctrl_drives_status(input logic [DW-1:0] v);
    return (v[5:4] == 2'b01) || (v[5:4] == 2'b10);
  endfunction

endpackage

// File: rtl/pmg_rst_sync.sv
module pmg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/pmg_addr_dec.sv
module pmg_addr_dec import pmg_pkg::*; #(
  parameter int SID_W    = 4,
  parameter int PID_W    = 8,
  parameter int N_INST   = 4,
  parameter int SID_SEL  = 0,
  parameter int PID_BASE = 'hC0,
  parameter int IDX_W    = 2
) (
  input  logic [SID_W-1:0]  sid,
  input  logic [PID_W-1:0]  pid,
  input  logic [OW-1:0]     off,
  output logic              addr_ok,
  output logic [IDX_W-1:0]  inst_idx,
  output logic [N_INST-1:0] inst_oh
);
  localparam logic [PID_W-1:0] PID_LO = PID_W'(PID_BASE);
  localparam logic [PID_W-1:0] PID_HI = PID_W'(PID_BASE + N_INST - 1);

  logic sid_ok, pid_ok, off_ok;

  always_comb begin
    sid_ok   = (sid == SID_W'(SID_SEL));
    pid_ok   = (pid >= PID_LO) && (pid <= PID_HI);
    off_ok   = (off <= OFF_LAST);
    addr_ok  = sid_ok && pid_ok && off_ok;
    inst_idx = pid[IDX_W-1:0];
  end

  for (genvar i = 0; i < N_INST; i++) begin : g_oh
    assign inst_oh[i] = addr_ok && (inst_idx == IDX_W'(i));
  end
endmodule

// File: rtl/pmg_gpio_bank.sv
module pmg_gpio_bank import pmg_pkg::*; (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [OW-1:0] off,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data
);
  logic [NSLOT-1:0][DW-1:0] q_all;
  logic [NSLOT-1:0]         hit;
  logic                     ctrl_mode_hit;
  logic [DW-1:0]            rv;

  always_comb
    ctrl_mode_hit = wr_en && (off == OFF_CTRL) &&
                    ctrl_drives_status(wr_data & CTRL_MASK);

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    localparam slot_t INFO = slot_info(s);
    logic [DW-1:0] q_s, d_s;
    logic          ce_s;

    assign hit[s]   = (off == INFO.off);
    assign q_all[s] = q_s;

    always_comb begin
      ce_s = wr_en;
      d_s  = q_s;
      if (wr_en && hit[s]) d_s = wr_data & INFO.mask;
      if (s == SLOT_STATUS && ctrl_mode_hit) d_s[0] = wr_data[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q_s <= INFO.rst;
      else if (ce_s) q_s <= d_s;
    end

    // R5: no stored bit ever lies outside the register's mask
    a_r5_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (q_s & ~INFO.mask) == '0);
  end

  always_comb begin
    rv = '0;
    if (off == OFF_ID0) rv = ID0_VAL;
    if (off == OFF_ID1) rv = ID1_VAL;
    for (int k = 0; k < NSLOT; k++)
      if (hit[k]) rv = q_all[k];
    rd_data = (q_all[SLOT_ENABLE] == '0) ? '0 : rv;
  end

  a_r6_status_follow: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_mode_hit |=> (q_all[SLOT_STATUS][0] == $past(wr_data[0])));

  a_r8_unlisted_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !(|hit)) |=> $stable(q_all));
endmodule

// File: rtl/pmg_regfile.sv
module pmg_regfile import pmg_pkg::*; #(
  parameter int SID_W    = 4,
  parameter int PID_W    = 8,
  parameter int N_INST   = 4,
  parameter int SID_SEL  = 0,
  parameter int PID_BASE = 'hC0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_vld,
  input  logic             req_wr,
  input  logic [SID_W-1:0] req_sid,
  input  logic [PID_W-1:0] req_pid,
  input  logic [7:0]       req_off,
  input  logic [7:0]       req_wdata,
  output logic [7:0]       rsp_rdata,
  output logic             rsp_err
);
  localparam int IDX_W = (N_INST > 1) ? $clog2(N_INST) : 1;

  logic                     rst_sync_n;
  logic                     addr_ok;
  logic [IDX_W-1:0]         inst_idx;
  logic [N_INST-1:0]        inst_oh;
  logic [N_INST-1:0][DW-1:0] bank_rd;
  logic [DW-1:0]            rdata_d;
  logic                     err_d;

  pmg_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pmg_addr_dec #(
    .SID_W(SID_W), .PID_W(PID_W), .N_INST(N_INST),
    .SID_SEL(SID_SEL), .PID_BASE(PID_BASE), .IDX_W(IDX_W)
  ) u_dec (
    .sid      (req_sid),
    .pid      (req_pid),
    .off      (req_off),
    .addr_ok  (addr_ok),
    .inst_idx (inst_idx),
    .inst_oh  (inst_oh)
  );

  for (genvar i = 0; i < N_INST; i++) begin : g_bank
    logic wr_en_i;
    assign wr_en_i = req_vld && req_wr && inst_oh[i];

    pmg_gpio_bank u_bank (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .wr_en   (wr_en_i),
      .off     (req_off),
      .wr_data (req_wdata),
      .rd_data (bank_rd[i])
    );
  end

  always_comb begin
    rdata_d = '0;
    err_d   = 1'b0;
    if (req_vld) begin
      if (!addr_ok)     err_d   = 1'b1;
      else if (!req_wr) rdata_d = bank_rd[inst_idx];
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_rdata <= rdata_d;
      rsp_err   <= err_d;
    end
  end

  a_r1_err_clean: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rsp_err |-> (rsp_rdata == '0));

  a_r2_one_bank: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(inst_oh));

  a_r9_err_needs_req: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(rsp_err) |-> $past(req_vld));

  a_r9_data_needs_read: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rsp_rdata != '0) |-> $past(req_vld && !req_wr));
endmodule

// File: tb/pmg_regfile_tb.sv
module pmg_regfile_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_vld = 1'b0;
  logic       req_wr = 1'b0;
  logic [3:0] req_sid = '0;
  logic [7:0] req_pid = '0;
  logic [7:0] req_off = '0;
  logic [7:0] req_wdata = '0;
  logic [7:0] rsp_rdata;
  logic       rsp_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] mdl [0:3][0:70];

  always #10 clk = ~clk;

  pmg_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_wr(req_wr),
    .req_sid(req_sid), .req_pid(req_pid), .req_off(req_off),
    .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err)
  );

  function automatic bit b_rd(input logic [7:0] o);
    return o == 8'h04 || o == 8'h05 || o == 8'h08 || o == 8'h40 ||
           o == 8'h41 || o == 8'h42 || o == 8'h45 || o == 8'h46;
  endfunction

  function automatic bit b_wr(input logic [7:0] o);
    return b_rd(o) && o != 8'h04 && o != 8'h05;
  endfunction

  function automatic logic [7:0] b_mask(input logic [7:0] o);
    case (o)
      8'h08: return 8'h81;
      8'h40: return 8'h7F;
      8'h41, 8'h42: return 8'h07;
      8'h45: return 8'h3F;
      8'h46: return 8'h80;
      default: return 8'h00;
    endcase
  endfunction

  function automatic string tag_of(input logic [7:0] o);
    if (o == 8'h04 || o == 8'h05) return "R4";
    if (o == 8'h08) return "R6";
    if (!b_rd(o)) return "R8";
    return "R5";
  endfunction

  task automatic check(input bit ok, input string tag, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual err/data=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [3:0] sid, input logic [7:0] pid, input logic [7:0] off,
                      input logic wr, input logic [7:0] wd, input string tag);
    bit ok;
    int i;
    logic [7:0] ed;
    logic ee;
    ok = (sid == 0) && (pid >= 8'hC0) && (pid <= 8'hC3) && (off <= 8'h46);
    i  = int'(pid[1:0]);
    ee = !ok;
    ed = 8'h00;
    if (ok && !wr && mdl[i][8'h46] != 0 && b_rd(off)) ed = mdl[i][off];
    if (ok && wr && b_wr(off)) begin
      mdl[i][off] = wd & b_mask(off);
      if (off == 8'h40 && (mdl[i][8'h40][5:4] == 2'b01 || mdl[i][8'h40][5:4] == 2'b10))
        mdl[i][8'h08][0] = wd[0];
    end
    req_vld = 1'b1; req_wr = wr; req_sid = sid; req_pid = pid;
    req_off = off; req_wdata = wd;
    @(negedge clk);
    req_vld = 1'b0;
    check(rsp_err === ee && rsp_rdata === ed, tag, {rsp_err, rsp_rdata}, {ee, ed});
  endtask

  task automatic rd_all(input int inst);
    for (int o = 0; o <= 8'h46; o++)
      xfer(4'd0, 8'hC0 + 8'(inst), 8'(o), 1'b0, 8'h00, tag_of(8'(o)));
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin
      for (int o = 0; o <= 70; o++) mdl[i][o] = 8'h00;
      mdl[i][8'h04] = 8'h10; mdl[i][8'h05] = 8'h05; mdl[i][8'h42] = 8'h04;
      mdl[i][8'h45] = 8'h01; mdl[i][8'h46] = 8'h80;
    end
    repeat (3) @(negedge clk);
    check(rsp_err === 1'b0 && rsp_rdata === 8'h00, "R10", {rsp_err, rsp_rdata}, 9'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(rsp_err === 1'b0 && rsp_rdata === 8'h00, "R9", {rsp_err, rsp_rdata}, 9'h0);

    // R3 / R8: reset contents of every set
    for (int i = 0; i < 4; i++) rd_all(i);

    // R5 / R4 / R8 / R2: distinct pattern written to every offset of each set
    for (int i = 0; i < 4; i++)
      for (int o = 0; o <= 8'h46; o++) begin
        logic [7:0] p;
        p = 8'(o * 29 + i * 71);
        if (o == 8'h46) p = p | 8'h80;
        xfer(4'd0, 8'hC0 + 8'(i), 8'(o), 1'b1, p, tag_of(8'(o)));
      end
    for (int i = 0; i < 4; i++) rd_all(i);

    // R6: every control mode with both data bit values
    for (int m = 0; m < 4; m++)
      for (int b = 0; b < 2; b++) begin
        xfer(4'd0, 8'hC1, 8'h08, 1'b1, {7'h40, ~1'(b)}, "R6");
        xfer(4'd0, 8'hC1, 8'h40, 1'b1, {2'b10, 2'(m), 3'b000, 1'(b)}, "R6");
        xfer(4'd0, 8'hC1, 8'h08, 1'b0, 8'h00, "R6");
        xfer(4'd0, 8'hC1, 8'h40, 1'b0, 8'h00, "R5");
      end

    // R7: disable gates reads; writes still land
    xfer(4'd0, 8'hC2, 8'h46, 1'b1, 8'h7F, "R7");
    rd_all(2);
    xfer(4'd0, 8'hC3, 8'h42, 1'b0, 8'h00, "R2");
    xfer(4'd0, 8'hC2, 8'h41, 1'b1, 8'h05, "R7");
    xfer(4'd0, 8'hC2, 8'h41, 1'b0, 8'h00, "R7");
    xfer(4'd0, 8'hC2, 8'h46, 1'b1, 8'hFF, "R7");
    xfer(4'd0, 8'hC2, 8'h41, 1'b0, 8'h00, "R7");
    rd_all(2);

    // R1: every address field out of range, reads and writes
    for (int s = 1; s < 16; s++) begin
      xfer(4'(s), 8'hC0, 8'h42, 1'b0, 8'h00, "R1");
      xfer(4'(s), 8'hC0, 8'h41, 1'b1, 8'h03, "R1");
    end
    for (int p = 0; p < 256; p++)
      if (p < 8'hC0 || p > 8'hC3) xfer(4'd0, 8'(p), 8'h42, 1'b0, 8'h00, "R1");
    for (int o = 8'h47; o < 256; o += 7) begin
      xfer(4'd0, 8'hC0, 8'(o), 1'b0, 8'h00, "R1");
      xfer(4'd0, 8'hC3, 8'(o), 1'b1, 8'hFF, "R1");
    end
    xfer(4'd0, 8'hBF, 8'h41, 1'b1, 8'h06, "R1");
    xfer(4'd0, 8'hC4, 8'h41, 1'b1, 8'h06, "R1");
    for (int i = 0; i < 4; i++) rd_all(i);

    // R9: back-to-back read then idle
    xfer(4'd0, 8'hC0, 8'h04, 1'b0, 8'h00, "R9");
    @(negedge clk);
    check(rsp_err === 1'b0 && rsp_rdata === 8'h00, "R9", {rsp_err, rsp_rdata}, 9'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule